// File: doc/BRIEF.md
# Move-Wide Immediate Register Unit

This block holds a single 64-bit destination register and updates it from move-wide immediate operations. Each operation carries a 16-bit unsigned immediate, a 2-bit lane select that places the immediate at bit offset 0, 16, 32 or 48, and an opcode. The opcode picks one of three merge behaviours. A zeroing move loads the shifted immediate and clears every other bit. A keeping move replaces only the selected 16-bit lane. An inverting move loads the complement of the shifted immediate.

Any 64-bit constant can be assembled in at most four operations: one zeroing or inverting move, followed by keeping moves that patch the remaining lanes. A size flag selects 64-bit or 32-bit operation. In 32-bit operation only the two low lanes can be addressed, and every result is zero-extended into the upper word. An operation that cannot be carried out leaves the register untouched and raises a one-cycle illegal flag.

Top module: `mvw_reg_unit`

## Requirements
- R1: While `rst_ni` is low, `value_o` is 0 and `illegal_o` is 0.
- R2: A valid operation with `op_i`=2'b00 (zeroing) sets `value_o`, at the next rising clock edge, to `imm_i` placed at bit offset 16*`hw_i`, with all other bits 0.
- R3: A valid operation with `op_i`=2'b10 (keeping) writes `imm_i` into bits [16*`hw_i`+15 : 16*`hw_i`] and leaves every other bit of the register unchanged.
- R4: A valid operation with `op_i`=2'b01 (inverting) sets the register to the bitwise complement of the shifted immediate. For example, immediate 0 with `hw_i`=0 yields all ones.
- R5: When `valid_i` is low, the register keeps its value and `illegal_o` is 0 at the following edge.
- R6: With `sf_i`=0 (32-bit operation), a legal operation leaves bits [63:32] of the register at 0. A keeping move in this mode preserves the other low-word lane.
- R7: With `sf_i`=0, a valid operation with `hw_i` of 2 or 3 is illegal. The register is left unchanged, and `illegal_o` is 1 for the one cycle after that edge.
- R8: A valid operation with `op_i`=2'b11 is illegal in either size mode. The register is left unchanged and `illegal_o` is 1 for the following cycle.
- R9: After any legal valid operation, `illegal_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 00 zeroing, 01 inverting, 10 keeping, 11 reserved |
| imm_i | input | 16 | Unsigned immediate |
| hw_i | input | 2 | Lane select; the immediate goes to bit offset 16*hw_i |
| sf_i | input | 1 | 1: 64-bit operation, 0: 32-bit operation |
| value_o | output | 64 | Register contents |
| illegal_o | output | 1 | One-cycle flag for a rejected valid operation |

## Verification
On every cycle the assertions check the following: the register holds when no operation is presented; the zeroing, inverting and keeping results match in 64-bit mode; the upper word stays clear in 32-bit mode; and a rejected operation sets the illegal flag without changing the register. Some behaviours need several operations in a row, and only the bench scenarios can show them. These include building a full 64-bit constant from four lanes, patching an inverted value with keeping moves, and a 32-bit keep that clears a previously populated upper word. A long random sequence, compared against the bench model on every clock, covers mixed modes and reserved opcodes.

// File: rtl/mvw_pkg.sv
package mvw_pkg;
  typedef enum logic [1:0] {
    MV_ZERO = 2'b00,
    MV_INV  = 2'b01,
    MV_KEEP = 2'b10,
    MV_RSVD = 2'b11
  } mv_op_e;
endpackage

// File: rtl/mvw_lane_place.sv
module mvw_lane_place #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  localparam int LANES = DATA_W / IMM_W,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] placed_o,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = (sel_i == SEL_W'(g));
    assign placed_o[g*IMM_W +: IMM_W] = hit ? imm_i : '0;
    assign mask_o[g*IMM_W +: IMM_W]   = {IMM_W{hit}};
  end
endmodule

// File: rtl/mvw_merge.sv
module mvw_merge #(
  parameter int DATA_W = 64,
  localparam int NARROW_W = DATA_W / 2
) (
  input  mvw_pkg::mv_op_e   op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] placed_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] nxt_o
);
  logic [DATA_W-1:0] raw;

  always_comb begin
    unique case (op_i)
      mvw_pkg::MV_ZERO: raw = placed_i;
      mvw_pkg::MV_INV:  raw = ~placed_i;
      mvw_pkg::MV_KEEP: raw = (cur_i & ~mask_i) | placed_i;
      default:          raw = cur_i;
    endcase
    nxt_o = raw;
    // narrow results are zero-extended
    if (!wide_i) nxt_o[DATA_W-1:NARROW_W] = '0;
  end
endmodule

// File: rtl/mvw_reg_unit.sv
module mvw_reg_unit #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  localparam int LANES = DATA_W / IMM_W,
  localparam int SEL_W = $clog2(LANES),
  localparam int NARROW_LANES = LANES / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SEL_W-1:0]  hw_i,
  input  logic              sf_i,
  output logic [DATA_W-1:0] value_o,
  output logic              illegal_o
);
  mvw_pkg::mv_op_e   op;
  logic [DATA_W-1:0] placed, mask, nxt;
  logic              legal;

  assign op    = mvw_pkg::mv_op_e'(op_i);
  assign legal = (op != mvw_pkg::MV_RSVD) &&
                 (sf_i || (hw_i < SEL_W'(NARROW_LANES)));

  mvw_lane_place #(.DATA_W(DATA_W), .IMM_W(IMM_W)) place_i (
    .imm_i    (imm_i),
    .sel_i    (hw_i),
    .placed_o (placed),
    .mask_o   (mask)
  );

  mvw_merge #(.DATA_W(DATA_W)) merge_i (
    .op_i     (op),
    .wide_i   (sf_i),
    .cur_i    (value_o),
    .placed_i (placed),
    .mask_i   (mask),
    .nxt_o    (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_o   <= '0;
      illegal_o <= 1'b0;
    end else begin
      illegal_o <= valid_i && !legal;
      if (valid_i && legal) value_o <= nxt;
    end
  end
endmodule

// File: rtl/mvw_reg_unit_chk.sv
module mvw_reg_unit_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  localparam int LANES = DATA_W / IMM_W,
  localparam int SEL_W = $clog2(LANES),
  localparam int NARROW_W = DATA_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [SEL_W-1:0]  hw_i,
  input logic              sf_i,
  input logic [DATA_W-1:0] value_o,
  input logic              illegal_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (value_o == '0 && !illegal_o));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(value_o) && !illegal_o));

  // R2
  zero_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sf_i && op_i == 2'b00) |=>
      value_o == (DATA_W'($past(imm_i)) << ($past(hw_i) * IMM_W)));

  // R4
  inv_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sf_i && op_i == 2'b01) |=>
      value_o == ~(DATA_W'($past(imm_i)) << ($past(hw_i) * IMM_W)));

  // R3
  keep_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sf_i && op_i == 2'b10) |=>
      IMM_W'(value_o >> ($past(hw_i) * IMM_W)) == $past(imm_i));

  // R6
  narrow_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sf_i && op_i != 2'b11 && hw_i < SEL_W'(LANES / 2)) |=>
      value_o[DATA_W-1:NARROW_W] == '0);

  // R7
  narrow_hw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sf_i && hw_i >= SEL_W'(LANES / 2)) |=>
      (illegal_o && $stable(value_o)));

  // R8
  rsvd_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b11) |=> (illegal_o && $stable(value_o)));

  // R9
  legal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 2'b11 && (sf_i || hw_i < SEL_W'(LANES / 2))) |=>
      !illegal_o);
endmodule

bind mvw_reg_unit mvw_reg_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (.*);

// File: tb/mvw_reg_unit_tb_top.sv
module mvw_reg_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [15:0] imm_i = '0;
  logic [1:0]  hw_i = '0;
  logic        sf_i = 1'b1;
  logic [63:0] value_o;
  logic        illegal_o;

  int errors = 0;
  int checks = 0;
  logic [63:0] exp_val = '0;
  logic        exp_ill = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  mvw_reg_unit dut_i (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  task automatic model(bit v, logic [1:0] op, logic [15:0] imm, logic [1:0] hw, bit sf);
    logic [63:0] ins, lane, n;
    int sh;
    if (!v) begin
      exp_ill = 0;
      return;
    end
    if (op == 2'd3 || (!sf && hw >= 2)) begin
      exp_ill = 1;
      return;
    end
    exp_ill = 0;
    sh = int'(hw) * 16;
    ins = {48'h0, imm} << sh;
    lane = 64'hFFFF << sh;
    case (op)
      2'd0: n = ins;
      2'd1: n = ~ins;
      default: n = (exp_val & ~lane) | ins;
    endcase
    if (!sf) n[63:32] = '0;
    exp_val = n;
  endtask

  task automatic step(string tag, bit v, logic [1:0] op, logic [15:0] imm,
                      logic [1:0] hw, bit sf);
    valid_i = v; op_i = op; imm_i = imm; hw_i = hw; sf_i = sf;
    @(posedge clk_i);
    model(v, op, imm, hw, sf);
    @(negedge clk_i);
    check(tag, value_o, exp_val);
    check(tag, {63'b0, illegal_o}, {63'b0, exp_ill});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check("R1", value_o, 64'h0);
    check("R1", {63'b0, illegal_o}, 64'h0);
    rst_ni = 1'b1;

    // R2 R3: build a full constant
    step("R2", 1, 2'd0, 16'h7788, 2'd0, 1);
    step("R3", 1, 2'd2, 16'h5566, 2'd1, 1);
    step("R3", 1, 2'd2, 16'h3344, 2'd2, 1);
    step("R3", 1, 2'd2, 16'h1122, 2'd3, 1);
    check("R3", value_o, 64'h1122334455667788);
    // R2 at an upper lane
    step("R2", 1, 2'd0, 16'h0001, 2'd1, 1);
    check("R2", value_o, 64'h0000_0000_0001_0000);
    // R4: all ones, then patch
    step("R4", 1, 2'd1, 16'h0000, 2'd0, 1);
    check("R4", value_o, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R3", 1, 2'd2, 16'h1234, 2'd2, 1);
    check("R3", value_o, 64'hFFFF_1234_FFFF_FFFF);
    step("R4", 1, 2'd1, 16'h00F0, 2'd3, 1);
    check("R4", value_o, 64'hFF0F_FFFF_FFFF_FFFF);
    // R5: idle with busy inputs
    step("R5", 0, 2'd0, 16'hDEAD, 2'd1, 1);
    step("R5", 0, 2'd3, 16'hBEEF, 2'd2, 0);
    check("R5", value_o, 64'hFF0F_FFFF_FFFF_FFFF);
    // R6: narrow keep clears upper word
    step("R6", 1, 2'd2, 16'hABCD, 2'd1, 0);
    check("R6", value_o, 64'h0000_0000_ABCD_FFFF);
    step("R6", 1, 2'd1, 16'h0001, 2'd0, 0);
    check("R6", value_o, 64'h0000_0000_FFFF_FFFE);
    // R7: narrow illegal lane
    step("R7", 1, 2'd0, 16'h5555, 2'd2, 0);
    check("R7", {63'b0, illegal_o}, 64'h1);
    step("R7", 1, 2'd2, 16'h5555, 2'd3, 0);
    check("R7", value_o, 64'h0000_0000_FFFF_FFFE);
    // R9: flag drops after a legal op
    step("R9", 1, 2'd2, 16'h0042, 2'd0, 0);
    check("R9", {63'b0, illegal_o}, 64'h0);
    // R8: reserved opcode in both modes
    step("R8", 1, 2'd3, 16'h9999, 2'd0, 1);
    check("R8", {63'b0, illegal_o}, 64'h1);
    step("R8", 1, 2'd3, 16'h9999, 2'd1, 0);
    check("R8", value_o, 64'h0000_0000_FFFF_0042);

    // mixed random sequence
    for (int i = 0; i < 400; i++) begin
      step("R2/R3/R4/R6", ($urandom % 4) != 0, 2'($urandom), 16'($urandom),
           2'($urandom), ($urandom % 3) != 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule